// File: doc/BRIEF.md
# TDM Serial Transmitter with Frame Pulse

This block sends per-channel bytes as one time-division-multiplexed serial stream and produces the 8 kHz frame pulse that goes with it. The pulse is derived only from the block's own bit clock. The block has three line formats. The first is a 24-channel format with one framing bit ahead of the channels, 193 bit periods per frame. The second is a 32-channel format with 256 bit periods per frame. The third is a 32-channel backplane format in which the clock runs at twice the data rate, so every data bit lasts two clock cycles.

Channel bytes are fetched one byte period ahead of their slot through a request/valid handshake. A channel with nothing valid in time is sent as the idle byte 0xFF. The serial output has an enable for an external tristate driver. The enable drops for masked channels, and it stays low for the whole frame when the link is switched off.

Top module: `tdm_tx`

## Requirements
- R1: `mode_i` selects the format: 0 = 24-channel (193 bit periods per frame), 1 = 32-channel (256 bit periods), 2 = backplane (256 bit periods of two clocks each, 512 clocks per frame). Frame position 0 is the first bit period after reset is released.
- R2: In modes 0 and 1, `fp_o` equals `fp_pol_i` for exactly the bit period at frame position 0 and equals its inverse at all other times. The value 1 means active high.
- R3: In mode 2, `fp_o` is low for one clock only, the second clock of bit period 255, which is the clock just ahead of the frame boundary. It is high at all other times.
- R4: Each channel byte goes out MSB first. Channel k fills bit periods 8k..8k+7 in modes 1 and 2, and 1+8k..8+8k in mode 0. In mode 2 each bit is held for two clocks.
- R5: In mode 0, bit period 0 carries `fbit_i`. The output enable is high there whenever the link is enabled.
- R6: `ser_oe_o` is low during the slot of any channel k whose `chan_en_i[k]` is 0. It is low for the entire frame while `link_en_i` is 0.
- R7: On the first clock of channel k's slot, `byte_req_o` pulses for one clock with `byte_chan_o` = k+1. The channel after the last channel is 0. The pulse is given only if that target channel is enabled and the link is on. `byte_chan_o` holds the target until the next slot starts.
- R8: The first byte presented with `byte_valid_i` high is the one sent. It may arrive on any clock from the request up to the last clock before the slot; in mode 0 that window for channel 0 includes the framing-bit period. If no valid byte arrives in that window, the channel carries 0xFF.
- R9: While `rst_ni` is low, the block sits at frame position 0. `fp_o` and `ser_oe_o` show the values that position calls for.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Transmit bit clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Format select: 0 24-channel, 1 32-channel, 2 backplane |
| fp_pol_i | input | 1 | Active level of the frame pulse in modes 0 and 1 |
| link_en_i | input | 1 | Link in use; 0 tristates the whole frame |
| chan_en_i | input | 32 | Per-channel enable mask, bit k for channel k |
| fbit_i | input | 1 | Framing bit value for mode 0 |
| byte_valid_i | input | 1 | Byte on byte_data_i is valid |
| byte_data_i | input | 8 | Channel byte supplied for byte_chan_o |
| byte_req_o | output | 1 | One-clock request for the next channel's byte |
| byte_chan_o | output | 5 | Channel whose byte is being fetched |
| ser_o | output | 1 | Serial data |
| ser_oe_o | output | 1 | Output enable for ser_o |
| fp_o | output | 1 | 8 kHz frame pulse |

## Verification
The bench tests the 193-bit period of the 24-channel format. A design that wraps at 192 or 194 shifts every frame pulse and every bit after the first frame. In the backplane format it checks that the pulse lasts one clock and not a whole bit, and that data changes only every second clock. It starves channels and delays valid bytes to the last clock of the fetch window, including the 24-channel case where channel 0's fetch window runs through the framing bit. A design that closes the window early, keeps the last byte instead of the first, or sends stale data instead of 0xFF then shows wrong bits. Sparse enable masks and a switched-off link catch enables that ignore the mask or do not track the channel slots.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned BIT_W  = $clog2(BYTE_W);
  localparam int unsigned CH_MAX = 32;
  localparam int unsigned CH_W   = $clog2(CH_MAX);
  localparam int unsigned T1_CH  = 24;
  localparam int unsigned POS_W  = $clog2(CH_MAX * BYTE_W) + 1;

  typedef enum logic [1:0] {
    MODE_T1 = 2'd0,
    MODE_E1 = 2'd1,
    MODE_BP = 2'd2
  } mode_e;

  typedef struct packed {
    logic            fbit;
    logic [CH_W-1:0] chan;
    logic [BIT_W-1:0] bitn;
  } slot_t;

  // frame position -> framing bit / channel / bit within byte
  function automatic slot_t slot_dec(input logic [POS_W-1:0] pos, input logic t1);
    logic [POS_W-1:0] q;
    slot_t s;
    q      = t1 ? pos - POS_W'(1) : pos;
    s.fbit = t1 && (pos == '0);
    s.chan = CH_W'(q >> BIT_W);
    s.bitn = q[BIT_W-1:0];
    return s;
  endfunction
endpackage

// File: rtl/tdm_tx_timer.sv
module tdm_tx_timer
  import tdm_tx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  output logic [POS_W-1:0] pos_o,
  output logic             half_o,
  output slot_t            slot_o,
  output logic             req_slot_o,
  output logic             load_o,
  output logic [CH_W-1:0]  target_o
);
  logic             t1, bp, step;
  logic [POS_W-1:0] pos_q, last;
  logic             half_q;
  logic [CH_W-1:0]  ch_last;
  slot_t            slot;

  assign t1      = (mode_i == MODE_T1);
  assign bp      = (mode_i == MODE_BP);
  assign last    = t1 ? POS_W'(T1_CH * BYTE_W) : POS_W'(CH_MAX * BYTE_W - 1);
  assign ch_last = t1 ? CH_W'(T1_CH - 1) : CH_W'(CH_MAX - 1);
  assign step    = !bp || half_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q  <= '0;
      half_q <= 1'b0;
    end else begin
      half_q <= bp && !half_q;
      if (step) pos_q <= (pos_q == last) ? '0 : pos_q + POS_W'(1);
    end
  end

  assign slot = slot_dec(pos_q, t1);

  // next clock starts a channel slot
  assign load_o = step && (slot.fbit ||
                  ((slot.bitn == BIT_W'(BYTE_W - 1)) && !(t1 && pos_q == last)));
  assign req_slot_o = !slot.fbit && (slot.bitn == '0) && !half_q;
  assign target_o   = (slot.fbit || slot.chan == ch_last) ? '0 : slot.chan + CH_W'(1);

  assign pos_o  = pos_q;
  assign half_o = half_q;
  assign slot_o = slot;
endmodule

// File: rtl/tdm_tx_fetch.sv
module tdm_tx_fetch
  import tdm_tx_pkg::*;
#(
  parameter logic [BYTE_W-1:0] IDLE_BYTE = 8'hFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_slot_i,
  input  logic              load_i,
  input  logic [CH_W-1:0]   target_i,
  input  logic              link_en_i,
  input  logic [CH_MAX-1:0] chan_en_i,
  input  logic              byte_valid_i,
  input  logic [BYTE_W-1:0] byte_data_i,
  output logic              byte_req_o,
  output logic [BYTE_W-1:0] cur_byte_o
);
  logic [BYTE_W-1:0] next_q, cur_q, eff;
  logic              held_q;

  assign byte_req_o = req_slot_i && link_en_i && chan_en_i[target_i];
  assign eff = held_q ? next_q : (byte_valid_i ? byte_data_i : IDLE_BYTE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      next_q <= IDLE_BYTE;
      cur_q  <= IDLE_BYTE;
      held_q <= 1'b0;
    end else begin
      if (req_slot_i) begin
        held_q <= byte_valid_i;
        next_q <= byte_data_i;
      end else if (!held_q && byte_valid_i) begin
        held_q <= 1'b1;
        next_q <= byte_data_i;
      end
      if (load_i) cur_q <= eff;
    end
  end

  assign cur_byte_o = cur_q;
endmodule

// File: rtl/tdm_tx_out.sv
module tdm_tx_out
  import tdm_tx_pkg::*;
(
  input  logic [1:0]        mode_i,
  input  logic              fp_pol_i,
  input  logic              link_en_i,
  input  logic [CH_MAX-1:0] chan_en_i,
  input  logic              fbit_i,
  input  logic [POS_W-1:0]  pos_i,
  input  logic              half_i,
  input  slot_t             slot_i,
  input  logic [BYTE_W-1:0] cur_byte_i,
  output logic              ser_o,
  output logic              ser_oe_o,
  output logic              fp_o
);
  logic [BIT_W-1:0] idx;

  assign idx      = BIT_W'(BYTE_W - 1) - slot_i.bitn;
  assign ser_o    = slot_i.fbit ? fbit_i : cur_byte_i[idx];
  assign ser_oe_o = link_en_i && (slot_i.fbit || chan_en_i[slot_i.chan]);

  always_comb begin
    if (mode_i == MODE_BP)
      fp_o = !((pos_i == POS_W'(CH_MAX * BYTE_W - 1)) && half_i);
    else
      fp_o = (pos_i == '0) ? fp_pol_i : !fp_pol_i;
  end
endmodule

// File: rtl/tdm_tx.sv
module tdm_tx
  import tdm_tx_pkg::*;
#(
  parameter logic [BYTE_W-1:0] IDLE_BYTE = 8'hFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic              fp_pol_i,
  input  logic              link_en_i,
  input  logic [CH_MAX-1:0] chan_en_i,
  input  logic              fbit_i,
  input  logic              byte_valid_i,
  input  logic [BYTE_W-1:0] byte_data_i,
  output logic              byte_req_o,
  output logic [CH_W-1:0]   byte_chan_o,
  output logic              ser_o,
  output logic              ser_oe_o,
  output logic              fp_o
);
  logic [POS_W-1:0]  pos;
  logic              half, req_slot, load;
  slot_t             slot;
  logic [CH_W-1:0]   target;
  logic [BYTE_W-1:0] cur_byte;

  tdm_tx_timer u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode_i),
    .pos_o      (pos),
    .half_o     (half),
    .slot_o     (slot),
    .req_slot_o (req_slot),
    .load_o     (load),
    .target_o   (target)
  );

  tdm_tx_fetch #(.IDLE_BYTE(IDLE_BYTE)) u_fetch (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_slot_i   (req_slot),
    .load_i       (load),
    .target_i     (target),
    .link_en_i    (link_en_i),
    .chan_en_i    (chan_en_i),
    .byte_valid_i (byte_valid_i),
    .byte_data_i  (byte_data_i),
    .byte_req_o   (byte_req_o),
    .cur_byte_o   (cur_byte)
  );

  tdm_tx_out u_out (
    .mode_i     (mode_i),
    .fp_pol_i   (fp_pol_i),
    .link_en_i  (link_en_i),
    .chan_en_i  (chan_en_i),
    .fbit_i     (fbit_i),
    .pos_i      (pos),
    .half_i     (half),
    .slot_i     (slot),
    .cur_byte_i (cur_byte),
    .ser_o      (ser_o),
    .ser_oe_o   (ser_oe_o),
    .fp_o       (fp_o)
  );

  assign byte_chan_o = target;
endmodule

// File: rtl/tdm_tx_chk.sv
module tdm_tx_chk
  import tdm_tx_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        mode_i,
  input logic              fp_pol_i,
  input logic              link_en_i,
  input logic [CH_MAX-1:0] chan_en_i,
  input logic              byte_req_o,
  input logic [CH_W-1:0]   byte_chan_o,
  input logic              ser_oe_o,
  input logic              fp_o
);
  assert_t1_chan_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_T1) |-> (byte_chan_o < CH_W'(T1_CH)));

  assert_gen_fp_width_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != MODE_BP && fp_o == fp_pol_i) |=> (!$stable(fp_pol_i) || fp_o != fp_pol_i));

  assert_bp_fp_width_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_BP && !fp_o) |=> fp_o);

  assert_link_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !link_en_i |-> !ser_oe_o);

  assert_req_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_req_o |=> !byte_req_o);

  assert_req_enabled_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_req_o |-> (link_en_i && chan_en_i[byte_chan_o]));
endmodule

bind tdm_tx tdm_tx_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mode_i      (mode_i),
  .fp_pol_i    (fp_pol_i),
  .link_en_i   (link_en_i),
  .chan_en_i   (chan_en_i),
  .byte_req_o  (byte_req_o),
  .byte_chan_o (byte_chan_o),
  .ser_oe_o    (ser_oe_o),
  .fp_o        (fp_o)
);

// File: tb/tdm_tx_bench.sv
module tdm_tx_bench;
  typedef struct packed {
    logic [1:0]  mode;
    logic        pol;
    logic        link;
    logic        fb;
    logic [31:0] en;
    logic [31:0] starve;
    logic [3:0]  lat;
    logic [7:0]  seed;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 1'b1, 1'b1, 1'b0, 32'hFFFF_FFFF, 32'h0000_0000, 4'd0,  8'h11},
    '{2'd1, 1'b0, 1'b1, 1'b0, 32'h0F0F_F00F, 32'h0000_0008, 4'd5,  8'h3C},
    '{2'd0, 1'b1, 1'b1, 1'b1, 32'h00FF_FFFF, 32'h0000_0000, 4'd2,  8'h77},
    '{2'd0, 1'b0, 1'b1, 1'b0, 32'h00A5_A5A5, 32'h0000_0020, 4'd7,  8'h02},
    '{2'd2, 1'b1, 1'b1, 1'b0, 32'hFFFF_FFFF, 32'h0000_0000, 4'd0,  8'h9E},
    '{2'd2, 1'b0, 1'b1, 1'b1, 32'hFFFF_0000, 32'h0001_0000, 4'd12, 8'h41},
    '{2'd1, 1'b1, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'h0000_0000, 4'd0,  8'h00},
    '{2'd0, 1'b1, 1'b0, 1'b1, 32'hFFFF_FFFF, 32'h0000_0000, 4'd0,  8'h00},
    '{2'd0, 1'b1, 1'b1, 1'b1, 32'h00FF_FFFF, 32'h0000_0000, 4'd8,  8'h55}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  mode_i = 2'd1;
  logic        fp_pol_i = 1'b1;
  logic        link_en_i = 1'b1;
  logic [31:0] chan_en_i = '1;
  logic        fbit_i = 1'b0;
  logic        byte_valid_i = 1'b0;
  logic [7:0]  byte_data_i = '0;
  logic        byte_req_o;
  logic [4:0]  byte_chan_o;
  logic        ser_o, ser_oe_o, fp_o;

  int   n_chk = 0;
  int   n_bad = 0;
  vec_t cur;
  bit   done = 1'b0;

  tdm_tx u_tdm_tx (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .fp_pol_i(fp_pol_i),
    .link_en_i(link_en_i), .chan_en_i(chan_en_i), .fbit_i(fbit_i),
    .byte_valid_i(byte_valid_i), .byte_data_i(byte_data_i),
    .byte_req_o(byte_req_o), .byte_chan_o(byte_chan_o),
    .ser_o(ser_o), .ser_oe_o(ser_oe_o), .fp_o(fp_o)
  );

  always #5 clk_i = ~clk_i;

  function automatic logic [7:0] pat(input int ch, input logic [7:0] seed);
    return (8'(ch * 29) + seed) ^ 8'h5A;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // byte supplier: first valid at lat clocks after the request, later bytes differ
  initial begin
    int since = 0;
    forever begin
      @(negedge clk_i);
      if (!rst_ni || byte_req_o) since = 0;
      else since++;
      byte_valid_i = !cur.starve[byte_chan_o] && (since >= int'(cur.lat));
      byte_data_i  = (since == int'(cur.lat)) ? pat(int'(byte_chan_o), cur.seed)
                                              : ~pat(int'(byte_chan_o), cur.seed);
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic apply(input vec_t v);
    cur       = v;
    mode_i    = v.mode;
    fp_pol_i  = v.pol;
    link_en_i = v.link;
    chan_en_i = v.en;
    fbit_i    = v.fb;
  endtask

  initial begin
    cur = VECS[0];
    // R9: reset state
    apply(VECS[0]);
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    chk(fp_o === 1'b1, "R9 fp in reset, mode 1", int'(fp_o), 1);
    chk(ser_oe_o === 1'b1, "R9 oe in reset, mode 1", int'(ser_oe_o), 1);
    apply(VECS[3]);
    @(negedge clk_i);
    chk(fp_o === 1'b0, "R9 fp in reset, mode 0 low polarity", int'(fp_o), 0);
    chk(ser_oe_o === 1'b1, "R9 oe on framing bit in reset", int'(ser_oe_o), 1);
    apply(VECS[4]);
    @(negedge clk_i);
    chk(fp_o === 1'b1, "R9 fp in reset, mode 2", int'(fp_o), 1);

    for (int vi = 0; vi < NV; vi++) begin
      int clen, L, nch;
      vec_t v;
      v = VECS[vi];
      rst_ni = 1'b0;
      apply(v);
      repeat (3) @(negedge clk_i);
      rst_ni = 1'b1;
      clen = (v.mode == 2'd0) ? 193 : (v.mode == 2'd2) ? 512 : 256;
      L    = (v.mode == 2'd0) ? 193 : 256;
      nch  = (v.mode == 2'd0) ? 24 : 32;
      for (int t = 0; t < 3 * clen; t++) begin
        int p, h, q, ch, b, tgt, win;
        logic fb, e_fp, e_oe, e_req, e_ser;
        logic [7:0] eb;
        bit idle;
        p  = (v.mode == 2'd2) ? (t / 2) % 256 : t % L;
        h  = (v.mode == 2'd2) ? t % 2 : 0;
        fb = (v.mode == 2'd0) && (p == 0);
        q  = (v.mode == 2'd0) ? p - 1 : p;
        ch = fb ? 0 : q / 8;
        b  = fb ? 0 : q % 8;
        tgt = (ch == nch - 1) ? 0 : ch + 1;
        if (v.mode == 2'd2) e_fp = !(p == 255 && h == 1);
        else e_fp = (p == 0) ? v.pol : !v.pol;
        e_oe  = v.link && (fb || v.en[ch]);
        e_req = !fb && b == 0 && h == 0 && v.link && v.en[tgt];
        win   = (v.mode == 2'd2) ? 16 : (v.mode == 2'd0 && ch == 0) ? 9 : 8;
        idle  = v.starve[ch] || (int'(v.lat) >= win);
        eb    = idle ? 8'hFF : pat(ch, v.seed);
        e_ser = fb ? v.fb : eb[7 - b];
        chk(fp_o === e_fp, (v.mode == 2'd2) ? "R1 R3 frame pulse" : "R1 R2 frame pulse",
            int'(fp_o), int'(e_fp));
        chk(ser_oe_o === e_oe, "R6 output enable", int'(ser_oe_o), int'(e_oe));
        chk(byte_req_o === e_req, "R7 byte request", int'(byte_req_o), int'(e_req));
        if (e_req)
          chk(int'(byte_chan_o) == tgt, "R7 requested channel", int'(byte_chan_o), tgt);
        if (e_oe && t >= clen)
          chk(ser_o === e_ser, fb ? "R5 framing bit" : (idle ? "R8 idle byte" : "R4 serial data"),
              int'(ser_o), int'(e_ser));
        @(negedge clk_i);
      end
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule